// File: doc/BRIEF.md
# Debug Address Match Unit

The unit holds a small bank of code-address slots (breakpoints) and a small bank of data-address slots (watchpoints). Software fills these slots through a single write port. Each cycle the unit compares the core's instruction fetch address against every armed breakpoint slot. It also compares any data access against every watchpoint slot. A watchpoint slot matches only when the access direction agrees with the slot's kind.

A watchpoint match raises a combinational squash signal in the same cycle as the access, so the memory stage can hold the access back before it commits. Both kinds of match are also reported one cycle later as registered pulses. Each pulse carries the number of the lowest-numbered matching slot, and the core's exception logic uses these pulses to enter its debug handler.

A slot is removed by writing it disarmed. That write sets its address back to zero. Removing a slot that is already empty leaves every slot as it was.

Top module: `dbg_match_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bp_hit`, `wp_hit`, `bp_slot`, `wp_slot` and `acc_squash` are all 0, and every slot is empty.
- R2: When `fetch_valid` is 1 and `fetch_pc` equals the address of an armed breakpoint slot, `bp_hit` is 1 in the next cycle only. A fetch held for N cycles gives N pulses.
- R3: A breakpoint slot whose arm bit is 0 never produces a hit, even when its stored address is equal to `fetch_pc`.
- R4: The watchpoint kind is 2 bits. Bit 0 allows reads (`acc_write`=0) and bit 1 allows writes (`acc_write`=1). 00 means off, 01 read only, 10 write only, 11 either. A hit needs `acc_valid`=1, an exact address match and an allowed direction. `wp_hit` then pulses in the next cycle.
- R5: A watchpoint slot of kind 00 never hits, even when its address matches.
- R6: The watchpoint compare is on one exact byte address. An access to the neighbouring address does not hit.
- R7: `acc_squash` is 1 in the same cycle as any watchpoint-matching access, and 0 otherwise.
- R8: When several slots of one bank match in the same cycle, a single pulse is raised and `bp_slot`/`wp_slot` give the lowest matching slot number. The slot field is 0 when there is no hit.
- R9: A write with `cfg_arm`=0 (breakpoint) or `cfg_kind`=00 (watchpoint) clears that slot. Clearing an empty slot leaves the other slots and their hits unchanged.
- R10: A slot write takes effect from the next cycle. A compare made in the same cycle as the write uses the old slot contents.
- R11: No hit is reported for a cycle whose `fetch_valid` (breakpoints) or `acc_valid` (watchpoints) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_watch | input | 1 | Write target: 0 selects the breakpoint bank, 1 the watchpoint bank |
| cfg_slot | input | SLOT_W (2) | Slot number to write |
| cfg_addr | input | ADDR_W (32) | Address to store |
| cfg_arm | input | 1 | Breakpoint arm bit (0 clears the slot) |
| cfg_kind | input | 2 | Watchpoint kind (00 clears the slot) |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | ADDR_W (32) | Fetch address |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | ADDR_W (32) | Data access byte address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_squash | output | 1 | Same-cycle watchpoint match; hold the access back |
| bp_hit | output | 1 | Registered breakpoint hit pulse |
| bp_slot | output | BP_IW (2) | Lowest matching breakpoint slot |
| wp_hit | output | 1 | Registered watchpoint hit pulse |
| wp_slot | output | WP_IW (2) | Lowest matching watchpoint slot |

## Verification
The in-line properties are checked on every cycle. They cover four points: a squash is always followed by a watchpoint pulse, no pulse appears without a valid fetch or access one cycle earlier, the reported slot was really matching, and a clearing write leaves the slot empty. Other behaviour is shown only by the bench scenarios, because it needs a model of the stored slots. This covers the direction filtering of each watchpoint kind, the exact-address rule, the lowest-slot choice, the same-cycle write ordering, and the rule that disarmed or off slots stay silent.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

   // Watchpoint kind: bit 0 allows reads, bit 1 allows writes.
   typedef enum logic [1:0] {
      WK_OFF   = 2'b00,
      WK_READ  = 2'b01,
      WK_WRITE = 2'b10,
      WK_ANY   = 2'b11
   } watch_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dbg_lowest_pick.sv
module dbg_lowest_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank #(
   parameter int unsigned NUM    = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_slot,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_arm,
   input  logic              pc_valid,
   input  logic [ADDR_W-1:0] pc,
   output logic [NUM-1:0]    match
);
   for (genvar i = 0; i < NUM; i++) begin : g_slot
      logic [ADDR_W-1:0] addr_q;
      logic              arm_q;
      logic              sel;

      assign sel = wr_en && (wr_slot == SW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
            arm_q  <= 1'b0;
         end else if (sel) begin
            arm_q  <= wr_arm;
            addr_q <= wr_arm ? wr_addr : '0;
         end
      end

      assign match[i] = pc_valid && arm_q && (pc == addr_q);

      // R9: a disarming write leaves the slot empty
      p_bp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && !wr_arm) |=> (!arm_q && addr_q == '0));
   end

endmodule

// File: rtl/dbg_wp_bank.sv
module dbg_wp_bank
   import dbg_match_pkg::*;
#(
   parameter int unsigned NUM    = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW-1:0]     wr_slot,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_kind,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic [NUM-1:0]    match
);
   for (genvar i = 0; i < NUM; i++) begin : g_slot
      logic [ADDR_W-1:0] addr_q;
      watch_kind_e       kind_q;
      logic              sel;
      logic              dir_ok;

      assign sel = wr_en && (wr_slot == SW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q <= '0;
            kind_q <= WK_OFF;
         end else if (sel) begin
            kind_q <= watch_kind_e'(wr_kind);
            addr_q <= (wr_kind == WK_OFF) ? '0 : wr_addr;
         end
      end

      assign dir_ok   = acc_write ? kind_q[1] : kind_q[0];
      assign match[i] = acc_valid && dir_ok && (acc_addr == addr_q);

      // R9: writing kind off leaves the slot empty
      p_wp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && wr_kind == WK_OFF) |=> (kind_q == WK_OFF && addr_q == '0));
   end

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbg_match_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NUM_BP = 4,
   parameter int unsigned NUM_WP = 4,
   localparam int unsigned BP_IW  = idx_width(NUM_BP),
   localparam int unsigned WP_IW  = idx_width(NUM_WP),
   localparam int unsigned SLOT_W = (BP_IW > WP_IW) ? BP_IW : WP_IW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_watch,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_arm,
   input  logic [1:0]        cfg_kind,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              acc_squash,
   output logic              bp_hit,
   output logic [BP_IW-1:0]  bp_slot,
   output logic              wp_hit,
   output logic [WP_IW-1:0]  wp_slot
);
   if (NUM_BP < 1 || NUM_WP < 1) begin : g_bad_count
      $error("dbg_match_unit: each bank needs at least one slot");
   end
   if (ADDR_W < 2) begin : g_bad_width
      $error("dbg_match_unit: ADDR_W too small");
   end

   logic [NUM_BP-1:0] bp_match;
   logic [NUM_WP-1:0] wp_match;
   logic              bp_any, wp_any;
   logic [BP_IW-1:0]  bp_pick;
   logic [WP_IW-1:0]  wp_pick;

   dbg_bp_bank #(.NUM(NUM_BP), .ADDR_W(ADDR_W), .SW(SLOT_W)) u_bp (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && !cfg_watch), .wr_slot(cfg_slot),
      .wr_addr(cfg_addr), .wr_arm(cfg_arm),
      .pc_valid(fetch_valid), .pc(fetch_pc),
      .match(bp_match)
   );

   dbg_wp_bank #(.NUM(NUM_WP), .ADDR_W(ADDR_W), .SW(SLOT_W)) u_wp (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && cfg_watch), .wr_slot(cfg_slot),
      .wr_addr(cfg_addr), .wr_kind(cfg_kind),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .match(wp_match)
   );

   dbg_lowest_pick #(.N(NUM_BP), .IW(BP_IW)) u_bp_pick (
      .req(bp_match), .any(bp_any), .idx(bp_pick)
   );

   dbg_lowest_pick #(.N(NUM_WP), .IW(WP_IW)) u_wp_pick (
      .req(wp_match), .any(wp_any), .idx(wp_pick)
   );

   assign acc_squash = wp_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_hit  <= 1'b0;
         bp_slot <= '0;
         wp_hit  <= 1'b0;
         wp_slot <= '0;
      end else begin
         bp_hit  <= bp_any;
         bp_slot <= bp_any ? bp_pick : '0;
         wp_hit  <= wp_any;
         wp_slot <= wp_any ? wp_pick : '0;
      end
   end

   // R7: a squashed access is always reported as a watchpoint hit
   p_squash_reported_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_squash |=> wp_hit);

   // R11: pulses only follow a presented fetch or access
   p_bp_needs_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> $past(fetch_valid));
   p_wp_needs_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(acc_valid));

   // R8: the reported slot was among the matching ones
   p_bp_slot_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> ((($past(bp_match) >> bp_slot) & NUM_BP'(1)) != '0));
   p_wp_slot_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> ((($past(wp_match) >> wp_slot) & NUM_WP'(1)) != '0));

endmodule

// File: tb/dbg_match_unit_tb.sv
`timescale 1ns/1ps
module dbg_match_unit_tb_top;

   localparam int AW = 32;
   localparam int NB = 4;
   localparam int NW = 4;

   typedef struct {
      logic       bp_hit;
      logic [1:0] bp_slot;
      logic       wp_hit;
      logic [1:0] wp_slot;
      string      tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 0, cfg_watch = 0, cfg_arm = 0;
   logic [1:0]    cfg_slot = 0, cfg_kind = 0;
   logic [AW-1:0] cfg_addr = 0, fetch_pc = 0, acc_addr = 0;
   logic          fetch_valid = 0, acc_valid = 0, acc_write = 0;
   logic          acc_squash, bp_hit, wp_hit;
   logic [1:0]    bp_slot, wp_slot;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   exp_t sb_q[$];

   logic [AW-1:0] m_bpa [NB];
   logic          m_bpe [NB];
   logic [AW-1:0] m_wpa [NW];
   logic [1:0]    m_wpk [NW];

   always #4 clk = ~clk;

   dbg_match_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_watch(cfg_watch), .cfg_slot(cfg_slot),
      .cfg_addr(cfg_addr), .cfg_arm(cfg_arm), .cfg_kind(cfg_kind),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_squash(acc_squash), .bp_hit(bp_hit), .bp_slot(bp_slot),
      .wp_hit(wp_hit), .wp_slot(wp_slot)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle of stimulus; the expectation comes from the bench's own slot model.
   task automatic step(input string tag,
                       input logic fv, input logic [AW-1:0] pc,
                       input logic av, input logic [AW-1:0] aa, input logic aw,
                       input logic we = 0, input logic watch = 0,
                       input logic [1:0] slot = 0, input logic [AW-1:0] addr = 0,
                       input logic arm = 0, input logic [1:0] kind = 0);
      exp_t e;
      @(negedge clk);
      fetch_valid = fv; fetch_pc = pc;
      acc_valid = av; acc_addr = aa; acc_write = aw;
      cfg_we = we; cfg_watch = watch; cfg_slot = slot;
      cfg_addr = addr; cfg_arm = arm; cfg_kind = kind;
      e.bp_hit = 0; e.bp_slot = 0; e.wp_hit = 0; e.wp_slot = 0; e.tag = tag;
      for (int i = NB - 1; i >= 0; i--)
         if (fv && m_bpe[i] && m_bpa[i] == pc) begin e.bp_hit = 1; e.bp_slot = 2'(i); end
      for (int i = NW - 1; i >= 0; i--)
         if (av && m_wpa[i] == aa && (aw ? m_wpk[i][1] : m_wpk[i][0])) begin
            e.wp_hit = 1; e.wp_slot = 2'(i);
         end
      sb_q.push_back(e);
      #1;
      check({tag, " R7 squash"}, 32'(acc_squash), 32'(e.wp_hit));
      if (we && !watch) begin
         m_bpe[slot] = arm; m_bpa[slot] = arm ? addr : '0;
      end
      if (we && watch) begin
         m_wpk[slot] = kind; m_wpa[slot] = (kind == 2'b00) ? '0 : addr;
      end
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 0, 0, 0);
   endtask

   // Monitor: compares each registered result with the queued expectation.
   always @(posedge clk) begin
      #2;
      if (rst_n && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check({e.tag, " bp_hit"},  32'(bp_hit),  32'(e.bp_hit));
         check({e.tag, " bp_slot"}, 32'(bp_slot), 32'(e.bp_slot));
         check({e.tag, " wp_hit"},  32'(wp_hit),  32'(e.wp_hit));
         check({e.tag, " wp_slot"}, 32'(wp_slot), 32'(e.wp_slot));
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NB; i++) begin m_bpa[i] = '0; m_bpe[i] = 0; end
      for (int i = 0; i < NW; i++) begin m_wpa[i] = '0; m_wpk[i] = 0; end
      fetch_valid = 1; fetch_pc = 0; acc_valid = 1; acc_addr = 0;
      repeat (3) @(negedge clk);
      check("R1 reset bp_hit", 32'(bp_hit), 0);
      check("R1 reset wp_hit", 32'(wp_hit), 0);
      check("R1 reset slots", 32'({bp_slot, wp_slot}), 0);
      check("R1 reset squash (empty slots)", 32'(acc_squash), 0);
      fetch_valid = 0; acc_valid = 0;
      rst_n = 1;
      step("R1 empty after reset", 1, 0, 1, 0, 0);

      // breakpoint programming
      step("cfg bp0", 0, 0, 0, 0, 0, 1, 0, 0, 32'h100, 1, 0);
      step("cfg bp2", 0, 0, 0, 0, 0, 1, 0, 2, 32'h200, 1, 0);
      step("R3 cfg bp3 disarmed", 0, 0, 0, 0, 0, 1, 0, 3, 32'h300, 0, 0);
      step("R2 fetch bp0", 1, 32'h100, 0, 0, 0);
      step("R2 fetch bp2", 1, 32'h200, 0, 0, 0);
      step("R2 fetch miss", 1, 32'h104, 0, 0, 0);
      step("R2 held fetch a", 1, 32'h100, 0, 0, 0);
      step("R2 held fetch b", 1, 32'h100, 0, 0, 0);
      step("R3 fetch disarmed slot", 1, 32'h300, 0, 0, 0);
      step("R11 fetch invalid", 0, 32'h100, 0, 0, 0);
      step("cfg bp1", 0, 0, 0, 0, 0, 1, 0, 1, 32'h200, 1, 0);
      step("R8 lowest bp", 1, 32'h200, 0, 0, 0);
      step("R10 write+fetch same cycle", 1, 32'h400, 0, 0, 0, 1, 0, 3, 32'h400, 1, 0);
      step("R10 fetch after write", 1, 32'h400, 0, 0, 0);
      step("R9 clear bp3", 0, 0, 0, 0, 0, 1, 0, 3, 32'h400, 0, 0);
      step("R9 fetch cleared", 1, 32'h400, 0, 0, 0);
      step("R9 clear empty bp3", 0, 0, 0, 0, 0, 1, 0, 3, 32'h0, 0, 0);
      step("R9 other slot unaffected", 1, 32'h100, 0, 0, 0);
      step("R9 cleared slot addr zero", 1, 32'h0, 0, 0, 0);

      // watchpoint programming
      step("cfg wp0 read", 0, 0, 0, 0, 0, 1, 1, 0, 32'h1000, 0, 2'b01);
      step("cfg wp1 write", 0, 0, 0, 0, 0, 1, 1, 1, 32'h1001, 0, 2'b10);
      step("cfg wp2 any", 0, 0, 0, 0, 0, 1, 1, 2, 32'h2000, 0, 2'b11);
      step("R5 cfg wp3 off", 0, 0, 0, 0, 0, 1, 1, 3, 32'h3000, 0, 2'b00);
      step("R4 read hits read-kind", 0, 0, 1, 32'h1000, 0);
      step("R4 write misses read-kind", 0, 0, 1, 32'h1000, 1);
      step("R4 write hits write-kind", 0, 0, 1, 32'h1001, 1);
      step("R4 read misses write-kind", 0, 0, 1, 32'h1001, 0);
      step("R4 read hits any-kind", 0, 0, 1, 32'h2000, 0);
      step("R4 write hits any-kind", 0, 0, 1, 32'h2000, 1);
      step("R5 off slot silent", 0, 0, 1, 32'h3000, 0);
      step("R5 off slot silent write", 0, 0, 1, 32'h3000, 1);
      step("R6 neighbour addr", 0, 0, 1, 32'h1002, 1);
      step("R6 lower neighbour", 0, 0, 1, 32'h1fff, 0);
      step("R11 access invalid", 0, 0, 0, 32'h2000, 1);
      step("cfg wp3 any", 0, 0, 0, 0, 0, 1, 1, 3, 32'h1000, 0, 2'b11);
      step("R8 write picks wp3", 0, 0, 1, 32'h1000, 1);
      step("R8 read picks wp0", 0, 0, 1, 32'h1000, 0);
      step("R2 R4 fetch and access together", 1, 32'h100, 1, 32'h2000, 1);
      step("R9 clear wp2", 0, 0, 0, 0, 0, 1, 1, 2, 32'h2000, 0, 2'b00);
      step("R9 cleared wp2 silent", 0, 0, 1, 32'h2000, 0);
      step("R9 wp0 still hits", 0, 0, 1, 32'h1000, 0);
      idle("tail a");
      idle("tail b");
      repeat (2) @(negedge clk);
      check("scoreboard drained", 32'(sb_q.size()), 0);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule